// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit external-memory pointers for a byte-oriented microcontroller core. Software reaches each pointer as a pair of 8-bit registers, a low byte and a high byte, through the core's special-function-register port. A fifth register, the pointer control register, does three things. It chooses which pointer drives the 16-bit address output. It can make that choice flip by itself each time the core finishes a pointer instruction. It sets, for each pointer separately, whether the pointer-step instruction adds one or subtracts one.

The core reports progress with two single-cycle strobes. One marks the completion of any pointer-related instruction, including the indexed table read from code memory. This strobe drives the automatic flip. The other marks the completion of the pointer-step instruction, which moves only the active pointer. The register port is a plain synchronous register interface with no back-pressure. Writes take effect at the clock edge. Reads return the addressed register combinationally from stored state. The address output follows the active pointer combinationally and needs no handshake.

The register addresses are parameters. Their defaults are: control at 0xC0, pointer 0 low byte at 0xC1, pointer 0 high byte at 0xC2, pointer 1 low byte at 0xC3, and pointer 1 high byte at 0xC4.

Top module: `dptr_unit`

## Requirements
- R1: After reset, all four pointer byte registers and the control register read 0x00, and the address output is 0x0000.
- R2: Each pointer byte register can be written and read back on its own. A read returns the stored byte whichever pointer is active.
- R3: Control bit 0 selects the active pointer (0 selects pointer 0, 1 selects pointer 1). The address output always equals the active pointer {high, low}, combinationally from state.
- R4: Control bits 0, 2, 4 and 5 read back as written. Bits 1, 3, 6 and 7 always read 0.
- R5: When control bit 2 is 1, a completed pointer instruction (ptr_op_done) inverts bit 0 at that clock edge. When bit 2 is 0, that strobe changes nothing.
- R6: A completed step instruction (ptr_inc_done) moves only the active pointer. It adds 1 when that pointer's direction bit is 0 and subtracts 1 when it is 1. Bit 5 is the direction bit for pointer 0 and bit 4 is the direction bit for pointer 1. The arithmetic wraps modulo 65536.
- R7: When the step strobe and an automatic flip occur in the same cycle, the step applies to the pointer that was active before the flip, using the direction bits from before that cycle's edge.
- R8: A software write to the control register in the same cycle as an automatic flip wins: bit 0 takes the written value.
- R9: A software write to a byte of the active pointer in the same cycle as a step stores the written byte. The pointer's other byte keeps its value, and no step is applied.
- R10: A read from any address outside the five mapped registers returns 0x00. A write to such an address changes no register.
- R11: With no write and no strobe in a cycle, the address output does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_we | input | 1 | Write enable for the addressed register |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data of the addressed register |
| ptr_op_done | input | 1 | Pointer-related instruction completed this cycle |
| ptr_inc_done | input | 1 | Pointer-step instruction completed this cycle |
| mem_addr | output | 16 | Active pointer, used for external-memory addressing |

## Verification
The assertions assume each strobe and each write is a one-cycle event sampled at the rising edge. They also assume the core may raise both strobes and a register write in any combination in the same cycle. For this reason the step and stability properties exclude cycles that contain a write or a flip, and separate properties cover the write-over-flip priority. The stimulus drives all inputs only at the falling edge. It picks addresses from the five mapped registers plus one unmapped address, and it raises the strobes independently at random. Every such overlap is therefore legal and occurs often, and directed cases cover wrap at 0xFFFF and 0x0000.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  // Control register bit positions; software depends on these positions.
  localparam int CTRL_SEL_BIT  = 0;
  localparam int CTRL_TOG_BIT  = 2;
  localparam int CTRL_DIR1_BIT = 4;
  localparam int CTRL_DIR0_BIT = 5;

  typedef struct packed {
    logic dir0;    // step direction of pointer 0, 1 = down
    logic dir1;    // step direction of pointer 1, 1 = down
    logic tog_en;  // flip selection after pointer instructions
    logic sel;     // active pointer
  } dptr_ctrl_t;

  function automatic logic [7:0] ctrl_pack(dptr_ctrl_t c);
    logic [7:0] b;
    b = 8'h00;
    b[CTRL_SEL_BIT]  = c.sel;
    b[CTRL_TOG_BIT]  = c.tog_en;
    b[CTRL_DIR1_BIT] = c.dir1;
    b[CTRL_DIR0_BIT] = c.dir0;
    return b;
  endfunction

  function automatic dptr_ctrl_t ctrl_unpack(logic [7:0] b);
    dptr_ctrl_t c;
    c.sel    = b[CTRL_SEL_BIT];
    c.tog_en = b[CTRL_TOG_BIT];
    c.dir1   = b[CTRL_DIR1_BIT];
    c.dir0   = b[CTRL_DIR0_BIT];
    return c;
  endfunction
endpackage

// File: rtl/dptr_ctrl_reg.sv
module dptr_ctrl_reg
  import dptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       op_done,
  output dptr_ctrl_t ctrl
);
  dptr_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl;
    if (wr_en) begin
      // software write overrides the automatic flip
      ctrl_d = ctrl_unpack(wdata);
    end else if (ctrl.tog_en && op_done) begin
      ctrl_d.sel = ~ctrl.sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_d;
  end
endmodule

// File: rtl/dptr_ptr_reg.sv
module dptr_ptr_reg #(
  parameter int BYTE_W    = 8,
  parameter int PTR_BYTES = 2,
  localparam int PTR_W    = BYTE_W * PTR_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PTR_BYTES-1:0] byte_we,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 step_en,
  input  logic                 step_down,
  output logic [PTR_W-1:0]     ptr
);
  logic [PTR_W-1:0] stepped;
  logic             any_we;

  assign any_we  = |byte_we;
  assign stepped = step_down ? (ptr - PTR_W'(1)) : (ptr + PTR_W'(1));

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_d;
    always_comb begin
      byte_d = ptr[b*BYTE_W +: BYTE_W];
      if (byte_we[b])            byte_d = wdata;
      else if (step_en && !any_we) byte_d = stepped[b*BYTE_W +: BYTE_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr[b*BYTE_W +: BYTE_W] <= '0;
      else        ptr[b*BYTE_W +: BYTE_W] <= byte_d;
    end
  end
endmodule

// File: rtl/dptr_rd_mux.sv
module dptr_rd_mux #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int NUM_PTR = 2,
  parameter int PTR_BYTES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC0,
  parameter logic [ADDR_W-1:0] PTR_BASE  = 8'hC1,
  localparam int PTR_W = BYTE_W * PTR_BYTES
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs,
  input  logic [BYTE_W-1:0]            ctrl_byte,
  output logic [BYTE_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) rdata = ctrl_byte;
    for (int p = 0; p < NUM_PTR; p++) begin
      for (int b = 0; b < PTR_BYTES; b++) begin
        if (addr == ADDR_W'(int'(PTR_BASE) + p*PTR_BYTES + b))
          rdata = ptrs[p][b*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
  import dptr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC0,
  parameter logic [ADDR_W-1:0] PTR_BASE  = 8'hC1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_we,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic              ptr_op_done,
  input  logic              ptr_inc_done,
  output logic [15:0]       mem_addr
);
  localparam int BYTE_W    = 8;
  localparam int PTR_BYTES = 2;
  localparam int PTR_W     = BYTE_W * PTR_BYTES;
  localparam int NUM_PTR   = 2;

  dptr_ctrl_t ctrl;
  logic [7:0] ctrl_q;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs;
  logic [NUM_PTR-1:0] dirs;

  assign ctrl_q  = ctrl_pack(ctrl);
  assign dirs[0] = ctrl.dir0;
  assign dirs[1] = ctrl.dir1;

  dptr_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sfr_we && (sfr_addr == CTRL_ADDR)),
    .wdata   (sfr_wdata),
    .op_done (ptr_op_done),
    .ctrl    (ctrl)
  );

  for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
    logic [PTR_BYTES-1:0] bwe;
    for (genvar b = 0; b < PTR_BYTES; b++) begin : g_we
      assign bwe[b] = sfr_we &&
        (sfr_addr == ADDR_W'(int'(PTR_BASE) + p*PTR_BYTES + b));
    end
    dptr_ptr_reg #(.BYTE_W(BYTE_W), .PTR_BYTES(PTR_BYTES)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_we   (bwe),
      .wdata     (sfr_wdata),
      .step_en   (ptr_inc_done && (ctrl.sel == 1'(p))),
      .step_down (dirs[p]),
      .ptr       (ptrs[p])
    );
  end

  dptr_rd_mux #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_PTR(NUM_PTR),
    .PTR_BYTES(PTR_BYTES), .CTRL_ADDR(CTRL_ADDR), .PTR_BASE(PTR_BASE)
  ) u_rd (
    .addr      (sfr_addr),
    .ptrs      (ptrs),
    .ctrl_byte (ctrl_q),
    .rdata     (sfr_rdata)
  );

  assign mem_addr = ptrs[ctrl.sel];
endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_we,
  input logic [7:0]        sfr_wdata,
  input logic [7:0]        sfr_rdata,
  input logic              ptr_op_done,
  input logic              ptr_inc_done,
  input logic [15:0]       mem_addr,
  input logic [7:0]        ctrl_q
);
  logic act_dir;
  logic ctrl_wr;
  assign act_dir = ctrl_q[0] ? ctrl_q[4] : ctrl_q[5];
  assign ctrl_wr = sfr_we && (sfr_addr == CTRL_ADDR);

  assert_ctrl_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == CTRL_ADDR) |-> ((sfr_rdata & 8'hCA) == 8'h00));

  assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2] && ptr_op_done && !ctrl_wr) |=> (ctrl_q[0] != $past(ctrl_q[0])));

  assert_no_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !ctrl_wr) |=> $stable(ctrl_q));

  assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc_done && !ptr_op_done && !sfr_we && !act_dir)
      |=> (mem_addr == $past(mem_addr) + 16'd1));

  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc_done && !ptr_op_done && !sfr_we && act_dir)
      |=> (mem_addr == $past(mem_addr) - 16'd1));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q[0] == $past(sfr_wdata[0])));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfr_we && !ptr_op_done && !ptr_inc_done) |=> $stable(mem_addr));
endmodule

bind dptr_unit dptr_unit_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sfr_addr     (sfr_addr),
  .sfr_we       (sfr_we),
  .sfr_wdata    (sfr_wdata),
  .sfr_rdata    (sfr_rdata),
  .ptr_op_done  (ptr_op_done),
  .ptr_inc_done (ptr_inc_done),
  .mem_addr     (mem_addr),
  .ctrl_q       (ctrl_q)
);

// File: tb/dptr_unit_bench.sv
`timescale 1ns/1ps
module dptr_unit_bench;
  localparam logic [7:0] A_CTRL = 8'hC0;
  localparam logic [7:0] A_L0 = 8'hC1, A_H0 = 8'hC2, A_L1 = 8'hC3, A_H1 = 8'hC4;
  localparam logic [7:0] A_BAD = 8'h55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic sfr_we = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic ptr_op_done = 1'b0;
  logic ptr_inc_done = 1'b0;
  logic [15:0] mem_addr;

  int checks = 0;
  int fails = 0;

  // bench model
  logic [15:0] m_ptr [2];
  logic m_sel, m_tog, m_d0, m_d1;

  always #2 clk = ~clk;

  dptr_unit u_dptr_unit (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_op_done(ptr_op_done),
    .ptr_inc_done(ptr_inc_done), .mem_addr(mem_addr)
  );

  function automatic logic [7:0] m_read(logic [7:0] a);
    case (a)
      A_CTRL:  return {2'b00, m_d0, m_d1, 1'b0, m_tog, 1'b0, m_sel};
      A_L0:    return m_ptr[0][7:0];
      A_H0:    return m_ptr[0][15:8];
      A_L1:    return m_ptr[1][7:0];
      A_H1:    return m_ptr[1][15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(logic [7:0] a);
    if (a == A_CTRL) return "R4";
    if (a >= A_L0 && a <= A_H1) return "R2";
    return "R10";
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_ptr[0] = 16'h0; m_ptr[1] = 16'h0;
    m_sel = 0; m_tog = 0; m_d0 = 0; m_d1 = 0;
  endtask

  // applies one clock edge to the model with the given inputs
  task automatic m_edge(logic [7:0] a, logic we, logic [7:0] wd, logic op, logic inc);
    logic os, od0, od1;
    os = m_sel; od0 = m_d0; od1 = m_d1;
    if (we && a == A_CTRL) begin
      m_sel = wd[0]; m_tog = wd[2]; m_d1 = wd[4]; m_d0 = wd[5];
    end else if (m_tog && op) begin
      m_sel = ~m_sel;
    end
    for (int i = 0; i < 2; i++) begin
      logic wl, wh, dn;
      wl = we && (a == (i == 0 ? A_L0 : A_L1));
      wh = we && (a == (i == 0 ? A_H0 : A_H1));
      dn = (i == 0) ? od0 : od1;
      if (wl) m_ptr[i][7:0] = wd;
      if (wh) m_ptr[i][15:8] = wd;
      if (!wl && !wh && inc && (os == 1'(i)))
        m_ptr[i] = dn ? m_ptr[i] - 16'd1 : m_ptr[i] + 16'd1;
    end
  endtask

  // one cycle: drive at falling edge, check pre-edge read and address, clock
  task automatic cyc(logic [7:0] a, logic we, logic [7:0] wd, logic op, logic inc);
    @(negedge clk);
    sfr_addr = a; sfr_we = we; sfr_wdata = wd; ptr_op_done = op; ptr_inc_done = inc;
    #1;
    chk(rd_tag(a), {8'h00, sfr_rdata}, {8'h00, m_read(a)});
    chk("R3", mem_addr, m_sel ? m_ptr[1] : m_ptr[0]);
    @(posedge clk);
    m_edge(a, we, wd, op, inc);
  endtask

  task automatic idle_rd(logic [7:0] a);
    cyc(a, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    #(4.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    logic [7:0] addrs [6];
    seed = 32'h1357;
    void'($urandom(seed));
    addrs = '{A_CTRL, A_L0, A_H0, A_L1, A_H1, A_BAD};
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 addr", mem_addr, 16'h0000);
    for (int k = 0; k < 5; k++) begin
      sfr_addr = addrs[k]; #1;
      chk("R1 reg", {8'h00, sfr_rdata}, 16'h0000);
    end

    // R2: byte writes and readback with pointer 0 active
    cyc(A_L0, 1, 8'h34, 0, 0); cyc(A_H0, 1, 8'h12, 0, 0);
    cyc(A_L1, 1, 8'hCD, 0, 0); cyc(A_H1, 1, 8'hAB, 0, 0);
    @(negedge clk); sfr_we = 0; sfr_addr = A_H1; #1;
    chk("R2 hi1", {8'h00, sfr_rdata}, 16'h00AB);
    chk("R3 ptr0", mem_addr, 16'h1234);
    // R3: select pointer 1
    cyc(A_CTRL, 1, 8'h01, 0, 0);
    idle_rd(A_L0);
    chk("R3 ptr1", mem_addr, 16'hABCD);
    // R4: unused bits read 0
    cyc(A_CTRL, 1, 8'hFF, 0, 0);
    idle_rd(A_CTRL);
    chk("R4 mask", {8'h00, sfr_rdata}, 16'h0035);
    // R6: wrap up on pointer 0 at FFFF
    cyc(A_CTRL, 1, 8'h00, 0, 0);
    cyc(A_L0, 1, 8'hFF, 0, 0); cyc(A_H0, 1, 8'hFF, 0, 0);
    cyc(A_BAD, 0, 8'h00, 0, 1);
    idle_rd(A_L0);
    chk("R6 wrap up", mem_addr, 16'h0000);
    // R6: down on pointer 0 wraps 0 -> FFFF; pointer 1 untouched
    cyc(A_CTRL, 1, 8'h20, 0, 0);
    cyc(A_BAD, 0, 8'h00, 0, 1);
    idle_rd(A_L1);
    chk("R6 wrap down", mem_addr, 16'hFFFF);
    chk("R6 other", {8'h00, sfr_rdata}, 16'h00CD);
    // R5: toggle disabled, strobe ignored
    cyc(A_BAD, 0, 8'h00, 1, 0);
    idle_rd(A_CTRL);
    chk("R5 off", {8'h00, sfr_rdata}, 16'h0020);
    // R7: toggle on, step + flip same cycle steps pointer 0 (down)
    cyc(A_CTRL, 1, 8'h24, 0, 0);
    cyc(A_BAD, 0, 8'h00, 1, 1);
    idle_rd(A_H0);
    chk("R7 sel", mem_addr, 16'hABCD);
    chk("R7 ptr0", {8'h00, sfr_rdata}, 16'h00FF);
    idle_rd(A_L0);
    chk("R7 ptr0 lo", {8'h00, sfr_rdata}, 16'h00FE);
    // R8: ctrl write sel=1 beats flip (currently sel=1)
    cyc(A_CTRL, 1, 8'h05, 1, 0);
    idle_rd(A_CTRL);
    chk("R8", {8'h00, sfr_rdata}, 16'h0005);
    // R9: write low byte of active pointer 1 with step
    cyc(A_L1, 1, 8'h10, 0, 1);
    idle_rd(A_H1);
    chk("R9", mem_addr, 16'hAB10);
    // R10: unmapped write ignored
    cyc(A_BAD, 1, 8'h77, 0, 0);
    idle_rd(A_BAD);
    chk("R10", {8'h00, sfr_rdata}, 16'h0000);
    chk("R10 addr", mem_addr, 16'hAB10);
    // R11: idle holds
    idle_rd(A_L0); idle_rd(A_L0);
    chk("R11", mem_addr, 16'hAB10);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      a = addrs[$urandom_range(0, 5)];
      cyc(a, ($urandom_range(0, 9) < 3), 8'($urandom), ($urandom_range(0, 9) < 3),
          ($urandom_range(0, 9) < 4));
    end
    idle_rd(A_CTRL);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule